// File: doc/BRIEF.md
# Outbound Post Queue Prefetch Port

This block sits between a host read port and an outbound post queue held as a circular buffer of 32-bit words in local memory. The local processor posts messages into memory and then advances a head index. Whenever the block's 32-bit prefetch register is empty, such a head update makes the block fetch the word at the tail index over a simple request/grant/response memory interface. The word is parked in the prefetch register and the tail index is advanced.

Host reads are served directly from the prefetch register. An empty register holds all ones, so a host read of an empty queue returns 0xFFFF_FFFF. While a fetch is in flight, host reads get a retry indication instead of wait states. A read with at least one byte enable consumes the parked word. If the queue still holds entries, that read launches the next fetch at once. An interrupt status output stays high while the queue holds data.

The queue occupies the third quarter of a region that starts at a base address. Its first word lies at the base plus twice the queue size in bytes.

Top module: `obq_prefetch_port`

## Requirements
- R1: After reset, head and tail indices are 0, the prefetch register holds 0xFFFF_FFFF, `irq_o` is 0 and `mem_req_o` is 0.
- R2: A host read while the prefetch register holds 0xFFFF_FFFF and no fetch is in flight returns 0xFFFF_FFFF with `host_retry_o` low and changes no state.
- R3: A head write made while the prefetch register is empty and no fetch is in flight, where the new head differs from the tail, raises `mem_req_o` in the next cycle. The address is `qbar_i + 2*QSIZE_BYTES + 4*tail`.
- R4: `mem_req_o` and `mem_addr_o` are held stable until a cycle with `mem_gnt_i` high. The fetch then completes on the first cycle with `mem_rvalid_i` high, and `mem_rdata_i` loads into the prefetch register.
- R5: From the request until the response, every host read sees `host_retry_o` high and has no effect.
- R6: Each completed fetch advances the tail by one word (4 bytes), wrapping modulo the queue size.
- R7: A host read with any byte enable set, while the prefetch register is valid, returns the word and empties the register. If head differs from tail, `mem_req_o` rises in the next cycle.
- R8: A host read with all byte enables low returns the prefetch register but consumes nothing and starts no fetch.
- R9: `irq_o` is high while the prefetch register is valid or head differs from tail. It falls once the last word has been read.
- R10: A head write while the prefetch register is valid starts no fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| qbar_i | input | AW | Queue region base address |
| head_we_i | input | 1 | Local processor head index write strobe |
| head_wdata_i | input | IDX_W | New head word index |
| host_rd_i | input | 1 | Host read of the queue port |
| host_be_i | input | 4 | Host byte enables |
| host_rdata_o | output | 32 | Read data (prefetch register) |
| host_retry_o | output | 1 | Retry response while a fetch is in flight |
| irq_o | output | 1 | Queue-holds-data interrupt status |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Memory read byte address |
| mem_gnt_i | input | 1 | Memory request accepted |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 32 | Memory read data |

## Verification
The bench sets QSIZE_BYTES to 16, a queue of four words. A handful of pops then carries the tail index across the wrap from word 3 back to word 0, and the fetch address must return to the queue start. The memory model answers with a latency of a few cycles and can hold off its grant. This keeps the retry window and the held request long enough to probe with host reads.

// File: rtl/obq_pkg.sv
package obq_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2
  } fetch_state_e;

  localparam logic [31:0] PF_EMPTY = 32'hFFFF_FFFF;
endpackage

// File: rtl/obq_ptr.sv
module obq_ptr #(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] load_val_i,
  input  logic             inc_i,
  output logic [IDX_W-1:0] ptr_o
);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= load_val_i;
    else if (inc_i)  ptr_q <= ptr_q + 1'b1; // wraps modulo queue size
  end

  assign ptr_o = ptr_q;

  AST_PTR_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !inc_i) |=> $stable(ptr_o)); // R6
endmodule

// File: rtl/obq_fetch_fsm.sv
module obq_fetch_fsm
  import obq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic gnt_i,
  input  logic rvalid_i,
  output logic req_o,
  output logic busy_o,
  output logic load_o
);
  fetch_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FS_IDLE: if (start_i)  state_d = FS_REQ;
      FS_REQ:  if (gnt_i)    state_d = FS_WAIT;
      FS_WAIT: if (rvalid_i) state_d = FS_IDLE;
      default:               state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= FS_IDLE;
    else         state_q <= state_d;
  end

  assign req_o  = (state_q == FS_REQ);
  assign busy_o = (state_q != FS_IDLE);
  assign load_o = (state_q == FS_WAIT) && rvalid_i;

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i) |=> req_o); // R4
  AST_LOAD_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !busy_o); // R4
endmodule

// File: rtl/obq_prefetch_port.sv
module obq_prefetch_port
  import obq_pkg::*;
#(
  parameter int AW          = 32,
  parameter int QSIZE_BYTES = 64,
  localparam int IDX_W      = $clog2(QSIZE_BYTES / 4)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    qbar_i,
  input  logic             head_we_i,
  input  logic [IDX_W-1:0] head_wdata_i,
  input  logic             host_rd_i,
  input  logic [3:0]       host_be_i,
  output logic [31:0]      host_rdata_o,
  output logic             host_retry_o,
  output logic             irq_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_gnt_i,
  input  logic             mem_rvalid_i,
  input  logic [31:0]      mem_rdata_i
);
  localparam logic [AW-1:0] POST_OFS = AW'(2 * QSIZE_BYTES);

  logic [IDX_W-1:0] head, tail, head_nxt;
  logic [31:0]      pf_q;
  logic             busy, load, start, pf_empty, consume;

  obq_ptr #(.IDX_W(IDX_W)) u_head (
    .clk_i, .rst_ni,
    .load_i(head_we_i), .load_val_i(head_wdata_i),
    .inc_i(1'b0), .ptr_o(head)
  );

  obq_ptr #(.IDX_W(IDX_W)) u_tail (
    .clk_i, .rst_ni,
    .load_i(1'b0), .load_val_i('0),
    .inc_i(load), .ptr_o(tail)
  );

  obq_fetch_fsm u_fsm (
    .clk_i, .rst_ni,
    .start_i(start), .gnt_i(mem_gnt_i), .rvalid_i(mem_rvalid_i),
    .req_o(mem_req_o), .busy_o(busy), .load_o(load)
  );

  assign pf_empty = (pf_q == PF_EMPTY);
  assign head_nxt = head_we_i ? head_wdata_i : head;
  // a read with no byte enables returns data but consumes nothing
  assign consume  = host_rd_i && !busy && (|host_be_i) && !pf_empty;
  assign start    = !busy && ((head_we_i && pf_empty) || consume) && (head_nxt != tail);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pf_q <= PF_EMPTY;
    else if (load)    pf_q <= mem_rdata_i;
    else if (consume) pf_q <= PF_EMPTY;
  end

  assign host_rdata_o = pf_q;
  assign host_retry_o = host_rd_i && busy;
  assign irq_o        = !pf_empty || (head != tail);
  assign mem_addr_o   = qbar_i + POST_OFS + AW'({tail, 2'b00});

  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i && !head_we_i) |=> $stable(mem_addr_o)); // R4
  AST_FETCH_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> irq_o); // R3
  AST_FETCH_INTO_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> pf_empty); // R10
  AST_PF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pf_empty && !(host_rd_i && |host_be_i)) |=> $stable(host_rdata_o)); // R8
  AST_TAIL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (tail == IDX_W'($past(tail) + 1'b1))); // R6
  AST_RETRY_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_retry_o && !mem_rvalid_i) |=> $stable(host_rdata_o)); // R5
endmodule

// File: tb/obq_prefetch_port_test.sv
module obq_prefetch_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int QSIZE_BYTES = 16;
  localparam int IDX_W = 2;
  localparam int LAT = 2;
  localparam logic [31:0] QBAR = 32'h0001_0000;
  localparam logic [31:0] QSTART = QBAR + 32'(2 * QSIZE_BYTES);

  logic clk = 1'b0, rst_n = 1'b0;
  logic head_we = 1'b0, host_rd = 1'b0;
  logic [IDX_W-1:0] head_wdata = '0;
  logic [3:0] host_be = '0;
  logic [31:0] host_rdata, mem_rdata = '0;
  logic host_retry, irq, mem_req, mem_rvalid = 1'b0, gnt_en = 1'b1;
  logic [AW-1:0] mem_addr, addr_cap = '0;
  logic pend = 1'b0;
  int cnt = 0, checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  obq_prefetch_port #(.AW(AW), .QSIZE_BYTES(QSIZE_BYTES)) uut (
    .clk_i(clk), .rst_ni(rst_n), .qbar_i(QBAR),
    .head_we_i(head_we), .head_wdata_i(head_wdata),
    .host_rd_i(host_rd), .host_be_i(host_be),
    .host_rdata_o(host_rdata), .host_retry_o(host_retry), .irq_o(irq),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_gnt_i(gnt_en),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] word_at(input logic [31:0] a);
    logic [31:0] off = a - QSTART;
    if (off >= 32'(QSIZE_BYTES) || off[1:0] != 2'b00) return 32'hDEAD_BEEF;
    return 32'hC0DE_0000 | (off >> 2);
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= word_at(addr_cap);
        pend       <= 1'b0;
      end else cnt <= cnt - 1;
    end
    if (mem_req && gnt_en) begin
      pend <= 1'b1; cnt <= LAT; addr_cap <= mem_addr;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic head_write(input int v);
    @(negedge clk); head_we = 1'b1; head_wdata = IDX_W'(v);
    @(negedge clk); head_we = 1'b0;
  endtask

  task automatic host_read(input logic [3:0] be, output logic [31:0] d, output logic r);
    @(negedge clk); host_rd = 1'b1; host_be = be;
    #1 d = host_rdata; r = host_retry;
    @(negedge clk); host_rd = 1'b0; host_be = '0;
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic r;
    check("R1 irq", 32'(irq), 0);
    check("R1 req", 32'(mem_req), 0);
    host_read(4'hF, d, r);
    check("R2 empty data", d, 32'hFFFF_FFFF);
    check("R2 no retry", 32'(r), 0);
    check("R2 no fetch", 32'(mem_req), 0);
  endtask

  task automatic t_single();
    logic [31:0] d; logic r;
    head_write(1);
    check("R3 req", 32'(mem_req), 1);
    check("R3 addr", mem_addr, QSTART);
    check("R9 irq pending", 32'(irq), 1);
    host_read(4'hF, d, r);
    check("R5 retry", 32'(r), 1);
    settle();
    host_read(4'h0, d, r);
    check("R8 be0 data", d, 32'hC0DE_0000);
    host_read(4'h0, d, r);
    check("R8 not consumed", d, 32'hC0DE_0000);
    check("R9 irq held", 32'(irq), 1);
    host_read(4'h1, d, r);
    check("R7 data", d, 32'hC0DE_0000);
    check("R7 no next fetch", 32'(mem_req), 0);
    check("R9 irq cleared", 32'(irq), 0);
    host_read(4'hF, d, r);
    check("R2 empty after pop", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_multi_wrap();
    logic [31:0] d; logic r;
    head_write(3);               // tail=1: words 1,2 queued
    check("R6 addr word1", mem_addr, QSTART + 4);
    settle();
    head_write(0);               // word 3 added, pf valid
    check("R10 no fetch", 32'(mem_req), 0);
    host_read(4'hF, d, r);
    check("R7 word1", d, 32'hC0DE_0001);
    check("R7 next req", 32'(mem_req), 1);
    check("R6 addr word2", mem_addr, QSTART + 8);
    settle();
    host_read(4'hF, d, r);
    check("R7 word2", d, 32'hC0DE_0002);
    settle();
    host_read(4'hF, d, r);
    check("R7 word3", d, 32'hC0DE_0003);
    check("R9 irq after last", 32'(irq), 0);
    head_write(1);
    check("R6 wrap addr", mem_addr, QSTART);
    settle();
    host_read(4'h8, d, r);
    check("R6 wrap data", d, 32'hC0DE_0000);
  endtask

  task automatic t_grant_hold();
    logic [31:0] d; logic r;
    gnt_en = 1'b0;
    head_write(2);
    repeat (3) @(negedge clk);
    check("R4 req held", 32'(mem_req), 1);
    check("R4 addr held", mem_addr, QSTART + 4);
    host_read(4'hF, d, r);
    check("R5 retry in req", 32'(r), 1);
    gnt_en = 1'b1;
    settle();
    host_read(4'hF, d, r);
    check("R4 data loaded", d, 32'hC0DE_0001);
    check("R5 no retry idle", 32'(r), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi_wrap();
    t_grant_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected <20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule